// File: doc/BRIEF.md
# Aperture Address Remapper

This block translates the addresses issued by a single bus master. The 32-bit space is cut into sixteen windows of 256 MB each. The top four address bits pick a window, and a per-window table entry then supplies two things: the number of the target slave, and the window index that replaces the original top nibble in the target's own address map. The low 28 bits pass through unchanged. A window whose slave number is zero is unmapped, and an access to it raises a decode error.

Software fills the table through four 32-bit configuration words. Two of them carry the slave numbers and two carry the replacement indices, one nibble per window. These writes land in a shadow copy that translation does not use. A separate commit word copies the whole shadow into the active table in a single step. While an access is in flight, the copy waits until the master goes idle, so one transaction never sees two different tables.

Top module: `aperture_remap`

## Requirements
- R1: The window index is `req_addr[31:28]`. For window i, `slv_sel` equals nibble bits [4(i mod 8)+3 : 4(i mod 8)] of the select word at byte offset 0x00 (windows 0..7) or 0x04 (windows 8..15) of the active table.
- R2: `out_addr[31:28]` equals the same nibble of the replacement word at offset 0x08 (windows 0..7) or 0x0C (windows 8..15), and `out_addr[27:0]` equals `req_addr[27:0]`.
- R3: `dec_err` is 1 exactly when `req_valid` is 1 and the selected window has slave number 0. It is 0 whenever `req_valid` is 0.
- R4: After reset, every window has slave 0 and replacement index 0. Every valid access then raises `dec_err`, and `out_addr[31:28]` is 0.
- R5: A write to offsets 0x00..0x0C changes only the shadow copy. Translation changes only after a write to offset 0x10 with `cfg_wdata[0]`=1, and if `req_valid` is 0 during that write, the new table is in use from the next cycle.
- R6: A write to offset 0x10 with `cfg_wdata[0]`=0 does not change the active table.
- R7: If the commit write arrives while `req_valid` is 1, the commit is held back until the first clock edge at which `req_valid` is 0. The active table does not change while `req_valid` stays 1.
- R8: A held-back commit copies the shadow contents present at the edge where it finally takes place, so shadow writes made between the commit write and that edge are included.
- R9: Writes to any `cfg_addr` other than 0x00, 0x04, 0x08, 0x0C and 0x10 change neither the shadow nor the active table. This includes offsets that are not word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 5 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Master access in flight |
| req_addr | input | 32 | Master address |
| slv_sel | output | 4 | Target slave number, 0 when unmapped |
| out_addr | output | 32 | Remapped address |
| dec_err | output | 1 | Access to an unmapped window |

## Verification
The assertions assume that `req_valid` stays high for the whole of a transaction, and that the inputs are known (non-X) after reset. The bench changes its inputs only just after a rising edge, so each transaction keeps `req_valid` high across all of its cycles. Random configuration writes are mixed with random toggling of `req_valid`, which exercises both held-back and immediate commits. Stray offsets are drawn deliberately, to show that they are ignored.

// File: rtl/ap_remap_pkg.sv
package ap_remap_pkg;
  localparam int ADDR_W    = 32;
  localparam int NUM_AP    = 16;
  localparam int AP_IDX_W  = $clog2(NUM_AP);
  localparam int FLD_W     = 4;
  localparam int CFG_W     = 32;
  localparam int CFG_AW    = 5;
  localparam int PER_WORD  = CFG_W / FLD_W;
  localparam int TBL_WORDS = NUM_AP / PER_WORD;
  localparam int TBL_W     = NUM_AP * FLD_W;
  localparam int WIDX_W    = CFG_AW - 2;
  // word indices (byte offset / 4)
  localparam int SEL_WORD0 = 0;
  localparam int OFF_WORD0 = SEL_WORD0 + TBL_WORDS;
  localparam int UPD_WORD  = OFF_WORD0 + TBL_WORDS;
  localparam logic [FLD_W-1:0] SLV_NONE = '0;

  function automatic logic [AP_IDX_W-1:0] ap_index(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: AP_IDX_W];
  endfunction

  function automatic logic [FLD_W-1:0] field_of(input logic [TBL_W-1:0] flat,
                                               input logic [AP_IDX_W-1:0] i);
    return flat[i*FLD_W +: FLD_W];
  endfunction

  function automatic logic [ADDR_W-1:0] remap_addr(input logic [FLD_W-1:0] ofs,
                                                  input logic [ADDR_W-1:0] a);
    return {ofs, a[ADDR_W-AP_IDX_W-1:0]};
  endfunction
endpackage

// File: rtl/ap_shadow_regs.sv
module ap_shadow_regs
  import ap_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [TBL_W-1:0]  sh_sel,
  output logic [TBL_W-1:0]  sh_off,
  output logic              upd_hit
);
  logic              aligned;
  logic [WIDX_W-1:0] widx;

  assign aligned = (cfg_addr[1:0] == 2'b00);
  assign widx    = cfg_addr[CFG_AW-1:2];
  assign upd_hit = cfg_wr && aligned && (widx == WIDX_W'(UPD_WORD)) && cfg_wdata[0];

  for (genvar r = 0; r < TBL_WORDS; r++) begin : g_word
    logic [CFG_W-1:0] sel_q, off_q;
    logic             sel_we, off_we;
    assign sel_we = cfg_wr && aligned && (widx == WIDX_W'(SEL_WORD0 + r));
    assign off_we = cfg_wr && aligned && (widx == WIDX_W'(OFF_WORD0 + r));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q <= '0;
        off_q <= '0;
      end else begin
        if (sel_we) sel_q <= cfg_wdata;
        if (off_we) off_q <= cfg_wdata;
      end
    end
    assign sh_sel[r*CFG_W +: CFG_W] = sel_q;
    assign sh_off[r*CFG_W +: CFG_W] = off_q;
  end
endmodule

// File: rtl/ap_commit_ctrl.sv
module ap_commit_ctrl
  import ap_remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_hit,
  input  logic             busy,
  input  logic [TBL_W-1:0] sh_sel,
  input  logic [TBL_W-1:0] sh_off,
  output logic [TBL_W-1:0] act_sel,
  output logic [TBL_W-1:0] act_off,
  output logic             commit_fire
);
  logic pend_q;
  logic commit_req;

  assign commit_req  = upd_hit | pend_q;
  assign commit_fire = commit_req & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      act_sel <= '0;
      act_off <= '0;
    end else begin
      pend_q <= commit_req & busy;
      if (commit_fire) begin
        act_sel <= sh_sel;
        act_off <= sh_off;
      end
    end
  end
endmodule

// File: rtl/ap_lookup.sv
module ap_lookup
  import ap_remap_pkg::*;
(
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TBL_W-1:0]  act_sel,
  input  logic [TBL_W-1:0]  act_off,
  output logic [FLD_W-1:0]  slv_sel,
  output logic [ADDR_W-1:0] out_addr,
  output logic              dec_err
);
  logic [AP_IDX_W-1:0] idx;

  always_comb begin
    idx      = ap_index(req_addr);
    slv_sel  = field_of(act_sel, idx);
    out_addr = remap_addr(field_of(act_off, idx), req_addr);
    dec_err  = req_valid && (slv_sel == SLV_NONE);
  end
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import ap_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [FLD_W-1:0]  slv_sel,
  output logic [ADDR_W-1:0] out_addr,
  output logic              dec_err
);
  logic [TBL_W-1:0] sh_sel, sh_off;
  logic [TBL_W-1:0] act_sel, act_off;
  logic             upd_hit;
  logic             commit_fire;

  ap_shadow_regs u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .sh_sel    (sh_sel),
    .sh_off    (sh_off),
    .upd_hit   (upd_hit)
  );

  ap_commit_ctrl u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_hit     (upd_hit),
    .busy        (req_valid),
    .sh_sel      (sh_sel),
    .sh_off      (sh_off),
    .act_sel     (act_sel),
    .act_off     (act_off),
    .commit_fire (commit_fire)
  );

  ap_lookup u_lookup (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .act_sel   (act_sel),
    .act_off   (act_off),
    .slv_sel   (slv_sel),
    .out_addr  (out_addr),
    .dec_err   (dec_err)
  );
endmodule

// File: rtl/ap_remap_chk.sv
module ap_remap_chk
  import ap_remap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [FLD_W-1:0]  slv_sel,
  input logic [ADDR_W-1:0] out_addr,
  input logic              dec_err,
  input logic              upd_hit,
  input logic              commit_fire,
  input logic [TBL_W-1:0]  act_sel,
  input logic [TBL_W-1:0]  act_off
);
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> req_valid); // R3

  AST_ERR_ONLY_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (slv_sel == SLV_NONE)); // R3

  AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> !req_valid); // R7

  AST_UPD_IDLE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_hit && !req_valid) |-> commit_fire); // R5

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> ($stable(act_sel) && $stable(act_off))); // R5

  AST_XLATE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid) && $stable(req_addr)) |->
      ($stable(slv_sel) && $stable(out_addr))); // R7
endmodule

bind aperture_remap ap_remap_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .slv_sel     (slv_sel),
  .out_addr    (out_addr),
  .dec_err     (dec_err),
  .upd_hit     (upd_hit),
  .commit_fire (commit_fire),
  .act_sel     (act_sel),
  .act_off     (act_off)
);

// File: tb/aperture_remap_tb_top.sv
module aperture_remap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  slv_sel;
  logic [31:0] out_addr;
  logic        dec_err;

  int errors = 0;
  int checks = 0;

  logic [3:0] m_sh_sel [16];
  logic [3:0] m_sh_off [16];
  logic [3:0] m_ac_sel [16];
  logic [3:0] m_ac_off [16];
  bit         m_pend;

  always #2 clk = ~clk;

  aperture_remap dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .slv_sel(slv_sel), .out_addr(out_addr), .dec_err(dec_err)
  );

  // one clock edge, with the reference model updated from the current inputs
  task automatic step();
    bit upd, creq;
    upd  = cfg_wr && (cfg_addr == 5'h10) && cfg_wdata[0];
    creq = upd || m_pend;
    if (creq && !req_valid)
      for (int i = 0; i < 16; i++) begin
        m_ac_sel[i] = m_sh_sel[i];
        m_ac_off[i] = m_sh_off[i];
      end
    m_pend = creq && req_valid;
    if (cfg_wr)
      for (int k = 0; k < 8; k++) begin
        case (cfg_addr)
          5'h00: m_sh_sel[k]   = cfg_wdata[4*k +: 4];
          5'h04: m_sh_sel[k+8] = cfg_wdata[4*k +: 4];
          5'h08: m_sh_off[k]   = cfg_wdata[4*k +: 4];
          5'h0C: m_sh_off[k+8] = cfg_wdata[4*k +: 4];
          default: ;
        endcase
      end
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  task automatic check_at(input logic [31:0] a, input string req);
    logic [3:0]  es;
    logic [31:0] ea;
    logic        ee;
    req_addr = a;
    #1;
    es = m_ac_sel[a[31:28]];
    ea = {m_ac_off[a[31:28]], a[27:0]};
    ee = req_valid && (es == 4'd0);
    checks++;
    if (slv_sel !== es || out_addr !== ea || dec_err !== ee) begin
      errors++;
      $display("FAIL %s addr=%h: sel=%0d addr=%h err=%b expected sel=%0d addr=%h err=%b",
               req, a, slv_sel, out_addr, dec_err, es, ea, ee);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++)
      check_at({i[3:0], $urandom() & 32'h0FFF_FFFF}, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin
      m_sh_sel[i] = 0; m_sh_off[i] = 0; m_ac_sel[i] = 0; m_ac_off[i] = 0;
    end
    m_pend = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R4: reset table, valid and idle
    req_valid = 1'b1;
    check_all("R4");
    req_valid = 1'b0;
    check_at(32'h8123_4567, "R3 idle no error");

    // R5: shadow writes without commit
    cfg_write(5'h00, 32'h0003_0021);
    cfg_write(5'h04, 32'h7E01_1111);
    cfg_write(5'h08, 32'h3210_FEDC);
    cfg_write(5'h0C, 32'hFEDC_BA98);
    req_valid = 1'b1;
    check_all("R5 before commit");
    // R6: commit word with bit0 clear
    req_valid = 1'b0;
    cfg_write(5'h10, 32'hFFFF_FFFE);
    req_valid = 1'b1;
    check_all("R6");
    req_valid = 1'b0;
    cfg_write(5'h10, 32'h1);
    req_valid = 1'b1;
    check_all("R1 R2 R3 after commit");
    check_at(32'h2ABC_DEF0, "R3 unmapped window 2");
    check_at(32'hF000_0001, "R1 window 15");

    // R9: stray offsets
    req_valid = 1'b0;
    cfg_write(5'h14, 32'h0);
    cfg_write(5'h01, 32'h0);
    cfg_write(5'h0E, 32'h0);
    cfg_write(5'h1C, 32'h0);
    cfg_write(5'h10, 32'h1);
    req_valid = 1'b1;
    check_all("R9");

    // R7, R8: commit during a transaction
    cfg_write(5'h00, 32'h5555_5555);
    cfg_write(5'h10, 32'h1);
    check_all("R7 held during transaction");
    cfg_write(5'h08, 32'h9999_9999);
    step();
    check_all("R7 still held");
    req_valid = 1'b0;
    step();
    req_valid = 1'b1;
    check_all("R8 deferred commit includes late write");

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [4:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 4) a = 5'(sel * 4);
      else if (sel < 7) a = 5'h10;
      else a = 5'($urandom_range(0, 31));
      req_valid = $urandom_range(0, 1);
      cfg_write(a, $urandom());
      if ($urandom_range(0, 2) == 0) begin
        req_valid = 1'b0;
        step();
      end
      req_valid = $urandom_range(0, 1);
      check_at($urandom(), "R1 R2 R3 R7 R8 R9 random");
      check_at($urandom(), "R1 R2 R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule